// File: doc/BRIEF.md
# Dual-Page-Size Associative Address Translator

This block turns a byte virtual address from a flat 45-bit workspace into a real memory address. It sits on the fetch path right after address generation and holds a small table of translations that is searched in parallel within a single cycle. Each table entry is tagged as mapping either a small page or a fixed 512 KiB large page. The small page size is a single global setting between 4 KiB and 64 KiB and may be changed while entries are resident. Every entry compares only the virtual address bits above its own page offset.

Entries are written one at a time through a load port. The target slot is chosen by a round-robin pointer, and a single pulse clears the whole table. A lookup returns the page frame of the matching entry with the in-page offset of the virtual address placed under it. If no valid entry matches, the lookup reports a miss and drives a zero address. If several entries match, the lowest-numbered one is used and a sticky error flag is raised.

Top module: `att_xlate`

## Requirements
- R1: After reset every entry is invalid, the load pointer is at slot 0 and `multi_err` is 0, so any lookup misses.
- R2: Small-page size follows `cfg_small`: codes 0,1,2,3,4 give 4 KiB, 8 KiB, 16 KiB, 32 KiB and 64 KiB offsets (12 to 16 bits). Codes 5, 6 and 7 act as code 0. On a hit, `lk_raddr` holds the stored frame bits above the offset and `lk_vaddr` bits below it, in the same cycle.
- R3: A large-page entry (`ld_large`=1) compares `lk_vaddr[44:19]` and passes a 19-bit offset, whatever the value of `cfg_small`.
- R4: With `lk_valid`=1 and no valid entry matching, `lk_miss`=1, `lk_hit`=0 and `lk_raddr`=0. With `lk_valid`=0, both `lk_hit` and `lk_miss` are 0.
- R5: A load writes the slot named by the pointer, and the pointer then advances by one modulo 16. The 17th load after reset therefore replaces slot 0.
- R6: When two or more valid entries match, the lowest-numbered one supplies `lk_raddr`. `multi_err` is set on the next edge and stays set until reset or invalidate-all.
- R7: `inv_all` clears every valid bit and `multi_err` in one cycle. A load in the same cycle is dropped and the pointer holds.
- R8: A load with `ld_valid`=0 uses up its slot and advances the pointer, but the entry it writes never matches.
- R9: Changing `cfg_small` changes the match width and offset of resident small-page entries from the next lookup, with no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_small | input | 3 | Small-page size code |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 45 | Lookup virtual byte address |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_miss | output | 1 | Lookup found no valid entry |
| lk_raddr | output | 32 | Translated real address, zero on miss |
| ld_en | input | 1 | Write one entry at the pointer slot |
| ld_vaddr | input | 45 | Virtual address of the page being loaded |
| ld_raddr | input | 32 | Real address of the frame being loaded |
| ld_large | input | 1 | Entry is a large page |
| ld_valid | input | 1 | Valid bit written into the entry |
| inv_all | input | 1 | Clear all entries |
| multi_err | output | 1 | Sticky multiple-match flag |

## Verification
The same resident entries are looked up at addresses on either side of each page boundary. This separates a match width that is right from one that is off by a bit. The tests then sweep all eight size codes against one small entry, which shows that the offset mask follows the code and that the reserved codes behave as 4 KiB. Overlapping small entries exercise the lowest-index priority and the sticky flag. A run of loads past the table size, an invalid load, and an invalidate that collides with a load together show that slot reuse and pointer behaviour agree with an independent model kept in the bench.

// File: rtl/att_pkg.sv
package att_pkg;
  localparam int MIN_OFF   = 12;
  localparam int LARGE_OFF = 19;
  localparam int OFF_W     = 5;

  typedef logic [OFF_W-1:0] off_t;

  // Offset width in bits for the global small-page size code.
  function automatic off_t small_off(input logic [2:0] code);
    off_t o;
    case (code)
      3'd1:    o = off_t'(13);
      3'd2:    o = off_t'(14);
      3'd3:    o = off_t'(15);
      3'd4:    o = off_t'(16);
      default: o = off_t'(MIN_OFF);
    endcase
    return o;
  endfunction
endpackage

// File: rtl/att_table.sv
module att_table #(
  parameter int N    = 16,
  parameter int VA_W = 45,
  parameter int RA_W = 32,
  localparam int VPN_W = VA_W - att_pkg::MIN_OFF,
  localparam int FRM_W = RA_W - att_pkg::MIN_OFF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_en,
  input  logic [VPN_W-1:0]            ld_vpn,
  input  logic [FRM_W-1:0]            ld_frame,
  input  logic                        ld_large,
  input  logic                        ld_valid,
  input  logic                        inv_all,
  output logic [N-1:0]                tab_valid,
  output logic [N-1:0][VPN_W-1:0]     tab_vpn,
  output logic [N-1:0][FRM_W-1:0]     tab_frame,
  output logic [N-1:0]                tab_large
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N - 1);

  logic [N-1:0]            valid_q, valid_d;
  logic [PTR_W-1:0]        ptr_q, ptr_d;
  logic [N-1:0][VPN_W-1:0] vpn_q;
  logic [N-1:0][FRM_W-1:0] frame_q;
  logic [N-1:0]            large_q;
  logic                    wr_go;

  assign wr_go = ld_en && !inv_all;

  always_comb begin
    valid_d = valid_q;
    ptr_d   = ptr_q;
    if (inv_all) begin
      valid_d = '0;
    end else if (ld_en) begin
      valid_d[ptr_q] = ld_valid;
      ptr_d          = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end

  // Payload storage: no reset, written only under the load enable.
  generate
    for (genvar g = 0; g < N; g++) begin : g_slot
      logic slot_we;
      assign slot_we = wr_go && (ptr_q == PTR_W'(g));
      always_ff @(posedge clk) begin
        if (slot_we) begin
          vpn_q[g]   <= ld_vpn;
          frame_q[g] <= ld_frame;
          large_q[g] <= ld_large;
        end
      end
    end
  endgenerate

  assign tab_valid = valid_q;
  assign tab_vpn   = vpn_q;
  assign tab_frame = frame_q;
  assign tab_large = large_q;

  p_inv_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0));
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> $stable(ptr_q));
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !inv_all) |=>
      (ptr_q == (($past(ptr_q) == PTR_LAST) ? '0 : $past(ptr_q) + 1'b1)));
  p_ptr_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !inv_all) |=> $stable(ptr_q));
endmodule

// File: rtl/att_match.sv
module att_match #(
  parameter int N    = 16,
  parameter int VA_W = 45,
  localparam int VPN_W = VA_W - att_pkg::MIN_OFF
) (
  input  logic [VPN_W-1:0]              lk_vpn,
  input  logic [2:0]                    cfg_small,
  input  logic [N-1:0]                  tab_valid,
  input  logic [N-1:0][VPN_W-1:0]       tab_vpn,
  input  logic [N-1:0]                  tab_large,
  output logic [N-1:0]                  match_vec,
  output logic [N-1:0][att_pkg::OFF_W-1:0] ent_off
);
  import att_pkg::*;

  off_t small_w;
  assign small_w = small_off(cfg_small);

  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      off_t             off_g;
      off_t             drop_g;
      logic [VPN_W-1:0] care_g;
      assign off_g     = tab_large[g] ? off_t'(LARGE_OFF) : small_w;
      assign drop_g    = off_g - off_t'(MIN_OFF);
      assign care_g    = {VPN_W{1'b1}} << drop_g;
      assign match_vec[g] = tab_valid[g] && (((lk_vpn ^ tab_vpn[g]) & care_g) == '0);
      assign ent_off[g]   = off_g;

      always_comb begin
        a_valid_gate_r8: assert (tab_valid[g] || !match_vec[g]);
      end
    end
  endgenerate
endmodule

// File: rtl/att_select.sv
module att_select #(
  parameter int N    = 16,
  parameter int RA_W = 32,
  localparam int FRM_W = RA_W - att_pkg::MIN_OFF
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             lk_valid,
  input  logic [RA_W-1:0]                  lk_va_low,
  input  logic [N-1:0]                     match_vec,
  input  logic [N-1:0][att_pkg::OFF_W-1:0] ent_off,
  input  logic [N-1:0][FRM_W-1:0]          tab_frame,
  input  logic                             inv_all,
  output logic                             lk_hit,
  output logic                             lk_miss,
  output logic [RA_W-1:0]                  lk_raddr,
  output logic                             multi_err
);
  import att_pkg::*;

  logic [FRM_W-1:0] win_frame;
  off_t             win_off;
  logic             any_match;
  logic             many_match;
  logic [RA_W-1:0]  low_mask;
  logic [RA_W-1:0]  full_frame;
  logic             err_q, err_d;

  // Descending scan so the lowest matching index is the last one written.
  always_comb begin
    win_frame = '0;
    win_off   = off_t'(MIN_OFF);
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        win_frame = tab_frame[i];
        win_off   = ent_off[i];
      end
    end
  end

  assign any_match  = |match_vec;
  assign many_match = ($countones(match_vec) > 1);
  assign low_mask   = (RA_W'(1) << win_off) - RA_W'(1);
  assign full_frame = {win_frame, {MIN_OFF{1'b0}}};

  always_comb begin
    lk_hit   = lk_valid && any_match;
    lk_miss  = lk_valid && !any_match;
    lk_raddr = '0;
    if (lk_hit) lk_raddr = (full_frame & ~low_mask) | (lk_va_low & low_mask);
  end

  always_comb begin
    err_d = err_q;
    if (inv_all)                      err_d = 1'b0;
    else if (lk_valid && many_match)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign multi_err = err_q;

  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_raddr == '0));
  p_hit_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss));
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));
  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_raddr[MIN_OFF-1:0] == lk_va_low[MIN_OFF-1:0]));
  p_multi_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && many_match && !inv_all) |=> multi_err);
  p_multi_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_err && !inv_all) |=> multi_err);
  p_multi_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !multi_err);
endmodule

// File: rtl/att_xlate.sv
module att_xlate #(
  parameter int N    = 16,
  parameter int VA_W = 45,
  parameter int RA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cfg_small,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_vaddr,
  output logic            lk_hit,
  output logic            lk_miss,
  output logic [RA_W-1:0] lk_raddr,
  input  logic            ld_en,
  input  logic [VA_W-1:0] ld_vaddr,
  input  logic [RA_W-1:0] ld_raddr,
  input  logic            ld_large,
  input  logic            ld_valid,
  input  logic            inv_all,
  output logic            multi_err
);
  import att_pkg::*;
  localparam int VPN_W = VA_W - MIN_OFF;
  localparam int FRM_W = RA_W - MIN_OFF;

  logic [N-1:0]               tab_valid;
  logic [N-1:0][VPN_W-1:0]    tab_vpn;
  logic [N-1:0][FRM_W-1:0]    tab_frame;
  logic [N-1:0]               tab_large;
  logic [N-1:0]               match_vec;
  logic [N-1:0][OFF_W-1:0]    ent_off;
  logic                       unused_ld_lsbs;

  assign unused_ld_lsbs = ^{ld_vaddr[MIN_OFF-1:0], ld_raddr[MIN_OFF-1:0]};

  att_table #(.N(N), .VA_W(VA_W), .RA_W(RA_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .ld_vpn    (ld_vaddr[VA_W-1:MIN_OFF]),
    .ld_frame  (ld_raddr[RA_W-1:MIN_OFF]),
    .ld_large  (ld_large),
    .ld_valid  (ld_valid),
    .inv_all   (inv_all),
    .tab_valid (tab_valid),
    .tab_vpn   (tab_vpn),
    .tab_frame (tab_frame),
    .tab_large (tab_large)
  );

  att_match #(.N(N), .VA_W(VA_W)) u_match (
    .lk_vpn    (lk_vaddr[VA_W-1:MIN_OFF]),
    .cfg_small (cfg_small),
    .tab_valid (tab_valid),
    .tab_vpn   (tab_vpn),
    .tab_large (tab_large),
    .match_vec (match_vec),
    .ent_off   (ent_off)
  );

  att_select #(.N(N), .RA_W(RA_W)) u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_va_low (lk_vaddr[RA_W-1:0]),
    .match_vec (match_vec),
    .ent_off   (ent_off),
    .tab_frame (tab_frame),
    .inv_all   (inv_all),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .lk_raddr  (lk_raddr),
    .multi_err (multi_err)
  );
endmodule

// File: tb/att_xlate_bench.sv
`timescale 1ns/1ps
module att_xlate_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_small;
  logic        lk_valid;
  logic [44:0] lk_vaddr;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_raddr;
  logic        ld_en, ld_large, ld_valid, inv_all;
  logic [44:0] ld_vaddr;
  logic [31:0] ld_raddr;
  logic        multi_err;

  always #10 clk = ~clk;

  att_xlate u_att_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_small(cfg_small),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_raddr(lk_raddr), .ld_en(ld_en),
    .ld_vaddr(ld_vaddr), .ld_raddr(ld_raddr), .ld_large(ld_large),
    .ld_valid(ld_valid), .inv_all(inv_all), .multi_err(multi_err)
  );

  int checks = 0;
  int failures = 0;

  // Reference model
  bit [44:0] m_va [N];
  bit [31:0] m_ra [N];
  bit        m_lg [N];
  bit        m_v  [N];
  int        m_ptr = 0;
  bit        m_multi = 0;

  typedef struct {
    bit        hit;
    bit [31:0] ra;
    string     req;
  } exp_t;
  exp_t sb[$];

  function automatic int small_bits(input bit [2:0] c);
    return (c <= 3'd4) ? 12 + int'(c) : 12;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: computes the expected result, queues it, then presents the lookup.
  task automatic lookup(input bit [44:0] va, input string req);
    exp_t e;
    int   cnt = 0;
    e.hit = 0; e.ra = '0; e.req = req;
    for (int i = 0; i < N; i++) begin
      int off = m_lg[i] ? 19 : small_bits(cfg_small);
      if (m_v[i] && ((va >> off) == (m_va[i] >> off))) begin
        if (!e.hit) begin
          bit [44:0] lowm = (45'd1 << off) - 45'd1;
          e.hit = 1;
          e.ra  = (m_ra[i] & ~lowm[31:0] & 32'hFFFF_F000) | (va[31:0] & lowm[31:0]);
        end
        cnt++;
      end
    end
    sb.push_back(e);
    lk_vaddr = va;
    lk_valid = 1'b1;
    @(posedge clk); #1;
    lk_valid = 1'b0;
    if (cnt > 1) m_multi = 1;
  endtask

  // Monitor: samples at the falling edge and compares with the queue head.
  always @(negedge clk) begin
    if (rst_n && lk_valid) begin
      exp_t e;
      if (sb.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard empty actual=%h expected=none", lk_raddr);
      end else begin
        e = sb.pop_front();
        check(e.req, {31'd0, lk_hit, lk_miss, lk_raddr}, {31'd0, e.hit, !e.hit, e.ra});
      end
    end
  end

  task automatic load(input bit [44:0] va, input bit [31:0] ra, input bit lg, input bit v);
    ld_vaddr = va; ld_raddr = ra; ld_large = lg; ld_valid = v; ld_en = 1'b1;
    @(posedge clk); #1;
    ld_en = 1'b0;
    m_va[m_ptr] = va; m_ra[m_ptr] = ra; m_lg[m_ptr] = lg; m_v[m_ptr] = v;
    m_ptr = (m_ptr + 1) % N;
  endtask

  initial begin
    #(20ns * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_lg[i] = 0; m_va[i] = '0; m_ra[i] = '0; end
    rst_n = 1'b0; cfg_small = 3'd0; lk_valid = 0; lk_vaddr = '0;
    ld_en = 0; ld_vaddr = '0; ld_raddr = '0; ld_large = 0; ld_valid = 0; inv_all = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    check("R1 multi_err after reset", multi_err, 0);
    lookup(45'h0_1234_5ABC, "R1 empty table misses");
    // R4 idle lookup quiet
    #5 check("R4 idle hit/miss", {lk_hit, lk_miss}, 0);

    load(45'h0_1234_5000, 32'h000A_B000, 0, 1);   // slot 0 small
    load(45'h1_2300_0000, 32'h0080_0000, 1, 1);   // slot 1 large
    lookup(45'h0_1234_5ABC, "R2 small 4K hit");
    lookup(45'h0_1234_6000, "R4 just above small page misses");
    lookup(45'h0_1234_4FFF, "R4 just below small page misses");
    lookup(45'h1_2307_FFFF, "R3 large top byte");
    lookup(45'h1_2308_0000, "R3 next large page misses");
    lookup(45'h1_2300_0000, "R3 large first byte");

    // R2/R9 size code sweep, reserved codes act as 4K
    for (int c = 0; c < 8; c++) begin
      cfg_small = 3'(c);
      lookup(45'h0_1234_7ABC, "R9 size code sweep near");
      lookup(45'h0_1235_8123, "R2 size code sweep 64K edge");
      lookup(45'h1_2301_2345, "R3 large ignores size code");
    end

    // R6 overlapping entries, lowest index wins
    cfg_small = 3'd4;
    load(45'h0_1234_0000, 32'h0055_0000, 0, 1);   // slot 2
    check("R6 multi_err before overlap", multi_err, 0);
    lookup(45'h0_1234_F00D, "R6 lowest index wins");
    check("R6 multi_err set", multi_err, m_multi);
    lookup(45'h1_2300_0040, "R6 single match after error");
    check("R6 multi_err sticky", multi_err, 1);

    // R8 invalid load
    cfg_small = 3'd0;
    load(45'h0_7700_0000, 32'h0011_1000, 0, 0);   // slot 3 invalid
    lookup(45'h0_7700_0123, "R8 invalid entry never matches");

    // R5 wrap: fill remaining slots, 17th load replaces slot 0
    for (int k = 0; k < 12; k++)
      load(45'h2_0000_0000 + (45'(k) << 20), 32'h0100_0000 + (32'(k) << 12), 0, 1);
    lookup(45'h2_0050_0777, "R5 filled slot hit");
    load(45'h0_9990_0000, 32'h00CC_D000, 0, 1);   // wraps to slot 0
    lookup(45'h0_9990_0321, "R5 wrapped load hits");
    lookup(45'h0_1234_5ABC, "R5 overwritten slot 0 gone");

    // R7 invalidate colliding with a load
    ld_vaddr = 45'h0_4444_4000; ld_raddr = 32'h0033_3000; ld_large = 0; ld_valid = 1;
    ld_en = 1'b1; inv_all = 1'b1;
    @(posedge clk); #1;
    ld_en = 1'b0; inv_all = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_multi = 0;
    check("R7 multi_err cleared", multi_err, 0);
    lookup(45'h0_4444_4010, "R7 dropped load absent");
    lookup(45'h0_9990_0321, "R7 previous entry cleared");
    load(45'h0_5555_5000, 32'h0066_6000, 0, 1);
    lookup(45'h0_5555_5FFF, "R7 load after invalidate");

    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule